// File: doc/BRIEF.md
# External Status Change Latch and Interrupt

This block watches the external and status conditions of one serial channel: carrier detect, sync, clear-to-send, transmit underrun and break. It also watches a baud-timer zero pulse. It assembles them into one status byte and raises an external/status interrupt request when a condition the software has enabled changes.

When an enabled condition changes, the block freezes the enabled bits at the values they took on that change. The request stays pending until software issues a reset-status command. Conditions that are not enabled stay transparent: their status bits follow the inputs at all times. Vector generation belongs to a neighbouring block.

All inputs are synchronous samples in the block's clock domain. The status byte and the request are plain level outputs. Nothing in the block streams, so there is no valid/ready handshake and no back-pressure.

Top module: `xs_status_latch`

## Requirements
- R1: Status bit 0 shows `rx_avail` and status bit 2 shows `tx_empty`, in the same cycle and whatever the latch state.
- R2: Status bits 3..7 carry carrier detect, sync, clear-to-send, transmit underrun and break, in that order. When a bit's enable (`cond_en` bit of the same position) is clear, the status bit follows its input and a change of that input raises no request.
- R3: A change of an enabled input has a set effect in the cycle after the clock edge that sees it. The enabled status bits then hold the values sampled at that edge, and the request becomes pending.
- R4: While the request is pending, further changes of enabled inputs are ignored and the frozen status bits do not move.
- R5: Break raises a request both on its rising edge and on its falling edge.
- R6: A one-cycle `tmr_zero` pulse with `cond_en[1]` set sets status bit 1 and raises the request. With `cond_en[1]` clear, the pulse leaves bit 1 at 0 and raises nothing.
- R7: A `rst_status` pulse releases the freeze: the bits follow their inputs again, status bit 1 clears and the request drops in the next cycle.
- R8: `irq` is the pending request gated by `master_en`. Clearing `master_en` masks `irq` without losing the pending state.
- R9: The first sampled cycle after reset never counts as a change, even if an enabled input is already high.
- R10: If an enabled change arrives in the same cycle as `rst_status`, the change wins: the block freezes again and the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_avail | input | 1 | Receive character available flag |
| tx_empty | input | 1 | Transmit buffer empty flag |
| cd_in | input | 1 | Carrier detect sample |
| sync_in | input | 1 | Sync input sample |
| cts_in | input | 1 | Clear-to-send sample |
| txund_in | input | 1 | Transmit underrun flag |
| brk_in | input | 1 | Break detected flag |
| tmr_zero | input | 1 | One-cycle pulse when the baud counter reaches zero |
| cond_en | input | 8 | Per-condition enables; bits 1 and 3..7 are used |
| master_en | input | 1 | Master enable for the status interrupt |
| rst_status | input | 1 | One-cycle reset-status command |
| status | output | 8 | Assembled status byte |
| irq | output | 1 | External/status interrupt request |

## Verification
The bench builds the block with its default configuration, which is fixed by the status bit layout: five watched inputs starting at bit 3. It sweeps every watched input with its enable both clear and set, and checks the rising change, the falling change while frozen, and the release. Separate sequences cover the following corners:
- break's second edge;
- masking by the master enable;
- gated and ungated timer pulses;
- all four values of the two pass-through bits;
- an input held high through reset;
- a change landing in the same cycle as the reset-status command.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int STATUS_W  = 8;
  localparam int WATCH_N   = 5;
  localparam int WATCH_LSB = 3;
  localparam int RX_BIT    = 0;
  localparam int TMR_BIT   = 1;
  localparam int TX_BIT    = 2;
  localparam logic [STATUS_W-1:0] EVT_MASK = 8'hFA;
endpackage

// File: rtl/xs_chg_detect.sv
module xs_chg_detect #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur,
  output logic [N-1:0] chg
);
  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic prev;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur[g];
      end
      assign chg[g] = primed & (prev ^ cur[g]);
    end
  endgenerate

  // R9
  no_first_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> chg == '0);
endmodule

// File: rtl/xs_hold_ctrl.sv
module xs_hold_ctrl
  import xs_pkg::*;
#(
  parameter int N = WATCH_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        cur,
  input  logic [N-1:0]        chg,
  input  logic [STATUS_W-1:0] cond_en,
  input  logic                tmr_zero,
  input  logic                rst_status,
  output logic                held,
  output logic [N-1:0]        snap,
  output logic                tmr_flag
);
  localparam int LSB = WATCH_LSB;

  logic [N-1:0] watch_en;
  logic         tmr_ev;
  logic         evt;

  assign watch_en = cond_en[LSB +: N];
  assign tmr_ev   = tmr_zero & cond_en[TMR_BIT];
  assign evt      = (|(chg & watch_en)) | tmr_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      snap <= '0;
    end else if (evt && (!held || rst_status)) begin
      held <= 1'b1;
      snap <= cur;
    end else if (rst_status) begin
      held <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_flag <= 1'b0;
    else        tmr_flag <= (tmr_flag & ~rst_status) | tmr_ev;
  end

  // R3
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && !rst_status |=> held);
  // R4
  snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held && !rst_status |=> $stable(snap));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_status && !evt |=> !held);
  // R6
  tmr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_flag && !(tmr_zero && cond_en[TMR_BIT]) |=> !tmr_flag);
  // R2
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held && ((cond_en & EVT_MASK) == '0) |=> !held);
endmodule

// File: rtl/xs_status_latch.sv
module xs_status_latch
  import xs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_avail,
  input  logic                tx_empty,
  input  logic                cd_in,
  input  logic                sync_in,
  input  logic                cts_in,
  input  logic                txund_in,
  input  logic                brk_in,
  input  logic                tmr_zero,
  input  logic [STATUS_W-1:0] cond_en,
  input  logic                master_en,
  input  logic                rst_status,
  output logic [STATUS_W-1:0] status,
  output logic                irq
);
  localparam int N   = WATCH_N;
  localparam int LSB = WATCH_LSB;

  logic [N-1:0] cur, chg, snap, watch_en, shown;
  logic         held, tmr_flag;

  assign cur      = {brk_in, txund_in, cts_in, sync_in, cd_in};
  assign watch_en = cond_en[LSB +: N];

  xs_chg_detect #(.N(N)) chg_i (
    .clk(clk), .rst_n(rst_n), .cur(cur), .chg(chg)
  );

  xs_hold_ctrl #(.N(N)) hold_i (
    .clk(clk), .rst_n(rst_n), .cur(cur), .chg(chg), .cond_en(cond_en),
    .tmr_zero(tmr_zero), .rst_status(rst_status), .held(held),
    .snap(snap), .tmr_flag(tmr_flag)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_mux
      assign shown[g] = (held && watch_en[g]) ? snap[g] : cur[g];
    end
  endgenerate

  always_comb begin
    status          = '0;
    status[RX_BIT]  = rx_avail;
    status[TX_BIT]  = tx_empty;
    status[TMR_BIT] = tmr_flag;
    status[LSB +: N] = shown;
  end

  assign irq = held & master_en;

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq);
  // R1
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[RX_BIT] == rx_avail && status[TX_BIT] == tx_empty);
endmodule

// File: tb/xs_status_latch_tb_top.sv
module xs_status_latch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_avail = 0, tx_empty = 0, tmr_zero = 0, master_en = 1, rst_status = 0;
  logic [4:0] ext = '0;
  logic [7:0] cond_en = '0;
  logic [7:0] status;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xs_status_latch dut_i (
    .clk(clk), .rst_n(rst_n), .rx_avail(rx_avail), .tx_empty(tx_empty),
    .cd_in(ext[0]), .sync_in(ext[1]), .cts_in(ext[2]), .txund_in(ext[3]),
    .brk_in(ext[4]), .tmr_zero(tmr_zero), .cond_en(cond_en),
    .master_en(master_en), .rst_status(rst_status), .status(status), .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic release_status();
    rst_status = 1'b1;
    step();
    rst_status = 1'b0;
    step();
  endtask

  initial begin
    ext = 5'b00001;
    cond_en = 8'h08;
    repeat (3) step();
    rst_n = 1'b1;
    step(); step();
    // R9: cd high through reset is not a change
    check("R9 irq after reset", {7'd0, irq}, 8'h00);
    check("R9 status after reset", status, 8'h08);
    ext = '0;
    step();
    release_status();
    check("R2 reset state clean", status, 8'h00);

    // R1: pass-through bits
    for (int v = 0; v < 4; v++) begin
      rx_avail = v[0];
      tx_empty = v[1];
      #1;
      check("R1 pass bits", status & 8'h05, {5'd0, v[1], 1'b0, v[0]});
    end
    rx_avail = 0;
    tx_empty = 0;

    // R2/R3/R4/R7 sweep
    for (int b = 0; b < 5; b++) begin
      for (int en = 0; en < 2; en++) begin
        cond_en = en ? (8'h01 << (b + 3)) : 8'h00;
        ext = '0;
        step();
        release_status();
        ext[b] = 1'b1;
        step();
        check(en ? "R3 rise frozen" : "R2 rise follows", status, 8'h01 << (b + 3));
        check(en ? "R3 irq pending" : "R2 no irq", {7'd0, irq}, en[7:0]);
        ext[b] = 1'b0;
        step();
        check(en ? "R4 fall ignored" : "R2 fall follows", status, en ? (8'h01 << (b + 3)) : 8'h00);
        check(en ? "R4 irq stays" : "R2 still no irq", {7'd0, irq}, en[7:0]);
        release_status();
        check("R7 released status", status, 8'h00);
        check("R7 released irq", {7'd0, irq}, 8'h00);
      end
    end

    // R5: break falling edge
    cond_en = 8'h80;
    ext = 5'b10000;
    step();
    release_status();
    check("R5 break high released", {7'd0, irq}, 8'h00);
    ext = '0;
    step();
    check("R5 break end irq", {7'd0, irq}, 8'h01);
    check("R5 break end status", status, 8'h00);
    ext = 5'b10000;
    step();
    check("R4 break restart ignored", status, 8'h00);
    ext = '0;
    step();
    release_status();

    // R8: master mask
    cond_en = 8'h08;
    master_en = 1'b0;
    ext = 5'b00001;
    step();
    check("R8 masked irq", {7'd0, irq}, 8'h00);
    master_en = 1'b1;
    #1;
    check("R8 pending kept", {7'd0, irq}, 8'h01);
    ext = '0;
    step();
    release_status();

    // R6: timer
    cond_en = 8'h00;
    tmr_zero = 1'b1;
    step();
    tmr_zero = 1'b0;
    check("R6 timer disabled status", status, 8'h00);
    check("R6 timer disabled irq", {7'd0, irq}, 8'h00);
    cond_en = 8'h02;
    tmr_zero = 1'b1;
    step();
    tmr_zero = 1'b0;
    check("R6 timer status", status, 8'h02);
    check("R6 timer irq", {7'd0, irq}, 8'h01);
    release_status();
    check("R7 timer cleared", status, 8'h00);
    check("R7 timer irq cleared", {7'd0, irq}, 8'h00);

    // R10: change in the reset-status cycle
    cond_en = 8'h08;
    ext = 5'b00001;
    step();
    ext = '0;
    rst_status = 1'b1;
    step();
    rst_status = 1'b0;
    check("R10 relatch irq", {7'd0, irq}, 8'h01);
    ext = 5'b00001;
    step();
    check("R10 relatch status", status, 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule